// File: doc/BRIEF.md
# SDRAM Single-Bank Write Sequencer

This block turns one write request into the full command sequence that a synchronous DRAM bank needs. The request names a bank, a row and a column and carries four data words. The block opens the row and issues a column write with automatic precharge turned off. It then drives the four-word burst, waits out write recovery, closes the bank with an explicit precharge and holds off the next row open until the row-cycle and precharge-recovery limits have passed.

Every timing limit is a parameter in picoseconds. The block converts each limit to whole clock cycles from a clock-period parameter, rounding up, so the same code meets the limits at any clock frequency. The request side is a simple valid/ready pair. A request is taken on a clock edge where both are high.

Top module: `sdram_wr_seq`

## Requirements
- R1: After reset, `ready` is 1, the command lines carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `dq_oe` is 0, `dqm` is all ones, and `ba` and `addr` are 0.
- R2: A request taken on an edge where `req_valid` and `ready` are both 1 puts ACTIVE (0011) on the command lines in the next cycle (cycle 0), with `req_bank` on `ba` and `req_row` on `addr`.
- R3: WRITE (0100) appears in cycle RCD = ceil(TRCD_PS/TCK_PS), with the same bank on `ba`, the column on `addr[COL_W-1:0]`, and `addr[10]` and all other address bits at 0.
- R4: Data word i (i = 0..3), taken from `req_data[i*DQ_W +: DQ_W]`, is on `dq_out` in cycle RCD+i. `dq_oe` is 1 in exactly those four cycles, and `dqm` is all zeros in them and all ones in every other cycle.
- R5: PRECHARGE (0010) appears in cycle PRE = max(RCD+3+ceil(TWR_PS/TCK_PS), ceil(TRAS_PS/TCK_PS)).
- R6: During PRECHARGE, `ba` carries the request's bank, `addr[10]` equals `req_all_banks` (1 = every bank, 0 = the named bank only), and all other address bits are 0.
- R7: `ready` is 0 from cycle 0 until cycle NXT-1, where NXT = max(PRE+ceil(TRP_PS/TCK_PS), ceil(TRC_PS/TCK_PS)). It is 1 in cycle NXT-1, so the earliest following ACTIVE falls in cycle NXT.
- R8: `req_valid` has no effect while `ready` is 0. A request held high through a sequence is taken at the first edge where `ready` is 1.
- R9: In every cycle of a sequence other than the ACTIVE, WRITE and PRECHARGE cycles, the command lines carry NOP and `ba` and `addr` are 0.
- R10: Reset taken in the middle of a sequence returns the outputs at once to the R1 state. A request after release runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_bank | input | BA_W | Bank to write |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_all_banks | input | 1 | Precharge closes every bank when 1 |
| req_data | input | 4*DQ_W | Four burst words, word 0 in the low bits |
| ready | output | 1 | A new request may be taken |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/column address, bit 10 selects the precharge scope |
| dqm | output | DQM_W | Byte masks, high = masked |
| dq_out | output | DQ_W | Write data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Taking a new request and finishing the row-cycle hold-off can happen on the same edge. The clearest case is the edge at the end of cycle NXT-1, when `ready` rises and the next ACTIVE is issued. The bench provokes this by holding `req_valid` high with the next request's payload for the whole of the previous sequence. It then checks that every cycle before NXT is NOP or part of the old sequence, and that ACTIVE, carrying the new row and bank, lands in exactly cycle NXT. The bench parameters round the write-recovery limit up from a fractional cycle count. They also make the write-recovery limit, rather than the row-active minimum, set the precharge cycle, and make the row-cycle minimum, rather than precharge recovery, set the ready cycle.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int BURST = 4;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_RECOV,
        ST_CLOSE
    } st_e;

    // Round a picosecond limit up to whole clocks, never below one.
    function automatic int ps_to_cyc(input int lim_ps, input int tck_ps);
        int c;
        c = (lim_ps + tck_ps - 1) / tck_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdw_age_ctr.sv
// Counts the cycles since ACTIVE; saturates at LIMIT.
module sdw_age_ctr #(
    parameter int LIMIT = 20,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)
            cnt_d = '0;
        else if (cnt_q == W'(LIMIT))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(LIMIT);
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sdw_burst_buf.sv
// Holds the burst words of the request in flight.
module sdw_burst_buf #(
    parameter int DQ_W  = 16,
    parameter int WORDS = 4,
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [WORDS*DQ_W-1:0] data_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic [DQ_W-1:0]       word_o
);
    logic [DQ_W-1:0] word_d [WORDS];
    logic [DQ_W-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_comb word_d[g] = load_i ? data_i[g*DQ_W +: DQ_W] : word_q[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[g] <= '0;
            else        word_q[g] <= word_d[g];
        end
    end

    assign word_o = word_q[sel_i];
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
    import sdw_pkg::*;
#(
    parameter int TCK_PS  = 7500,
    parameter int TRCD_PS = 20000,
    parameter int TRAS_PS = 44000,
    parameter int TWR_PS  = 15000,
    parameter int TRC_PS  = 66000,
    parameter int TRP_PS  = 20000,
    parameter int BA_W    = 2,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 10,
    parameter int ADDR_W  = 13,
    parameter int DQ_W    = 16,
    parameter int DQM_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [BA_W-1:0]       req_bank,
    input  logic [ROW_W-1:0]      req_row,
    input  logic [COL_W-1:0]      req_col,
    input  logic                  req_all_banks,
    input  logic [BURST*DQ_W-1:0] req_data,
    output logic                  ready,
    output logic                  cs_n,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic [BA_W-1:0]       ba,
    output logic [ADDR_W-1:0]     addr,
    output logic [DQM_W-1:0]      dqm,
    output logic [DQ_W-1:0]       dq_out,
    output logic                  dq_oe
);
    // Cycle counts, relative to the ACTIVE cycle (cycle 0).
    localparam int RCD_C = ps_to_cyc(TRCD_PS, TCK_PS);
    localparam int RAS_C = ps_to_cyc(TRAS_PS, TCK_PS);
    localparam int WR_C  = ps_to_cyc(TWR_PS,  TCK_PS);
    localparam int RC_C  = ps_to_cyc(TRC_PS,  TCK_PS);
    localparam int RP_C  = ps_to_cyc(TRP_PS,  TCK_PS);
    localparam int PRE_T = imax(RCD_C + BURST - 1 + WR_C, RAS_C);
    localparam int NXT_T = imax(PRE_T + RP_C, RC_C);
    localparam int CNT_W = $clog2(NXT_T + 1);
    localparam int IDX_W = $clog2(BURST);
    localparam int PRE_BIT = 10;

    typedef struct packed {
        st_e               st;
        logic              rdy;
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic [DQM_W-1:0]  dqm;
        logic [DQ_W-1:0]   dq;
        logic              oe;
        logic [IDX_W-1:0]  idx;
        logic [BA_W-1:0]   bank;
        logic [COL_W-1:0]  col;
        logic              all;
    } regs_t;

    regs_t r_d, r_q;

    logic             accept;
    logic [CNT_W-1:0] cnt_q;
    logic [DQ_W-1:0]  word;
    int               t_n;
    logic             go_idle;

    assign accept = req_valid && r_q.rdy;

    sdw_age_ctr #(.LIMIT(NXT_T), .W(CNT_W)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (accept),
        .cnt_o (cnt_q)
    );

    sdw_burst_buf #(.DQ_W(DQ_W), .WORDS(BURST)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .data_i (req_data),
        .sel_i  (r_q.idx),
        .word_o (word)
    );

    always_comb begin
        t_n     = int'(cnt_q) + 1;
        go_idle = (t_n + 1 >= NXT_T);

        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.ba   = '0;
        r_d.addr = '0;
        r_d.dqm  = '1;
        r_d.oe   = 1'b0;
        r_d.dq   = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st   = ST_OPEN;
                    r_d.rdy  = 1'b0;
                    r_d.cmd  = CMD_ACT;
                    r_d.ba   = req_bank;
                    r_d.addr = ADDR_W'(req_row);
                    r_d.bank = req_bank;
                    r_d.col  = req_col;
                    r_d.all  = req_all_banks;
                    r_d.idx  = '0;
                end
            end
            ST_OPEN: begin
                if (t_n == RCD_C) begin
                    r_d.st   = ST_DATA;
                    r_d.cmd  = CMD_WR;
                    r_d.ba   = r_q.bank;
                    r_d.addr = ADDR_W'(r_q.col);
                    r_d.addr[PRE_BIT] = 1'b0;
                    r_d.dq   = word;
                    r_d.oe   = 1'b1;
                    r_d.dqm  = '0;
                    r_d.idx  = r_q.idx + 1'b1;
                end
            end
            ST_DATA: begin
                r_d.dq  = word;
                r_d.oe  = 1'b1;
                r_d.dqm = '0;
                if (r_q.idx == IDX_W'(BURST - 1)) begin
                    r_d.st  = ST_RECOV;
                    r_d.idx = '0;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_RECOV: begin
                if (t_n == PRE_T) begin
                    r_d.cmd  = CMD_PRE;
                    r_d.ba   = r_q.bank;
                    r_d.addr[PRE_BIT] = r_q.all;
                    r_d.st   = go_idle ? ST_IDLE : ST_CLOSE;
                    r_d.rdy  = go_idle;
                end
            end
            ST_CLOSE: begin
                if (go_idle) begin
                    r_d.st  = ST_IDLE;
                    r_d.rdy = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.rdy  <= 1'b1;
            r_q.cmd  <= CMD_NOP;
            r_q.dqm  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready  = r_q.rdy;
    assign {cs_n, ras_n, cas_n, we_n} = r_q.cmd;
    assign ba     = r_q.ba;
    assign addr   = r_q.addr;
    assign dqm    = r_q.dqm;
    assign dq_out = r_q.dq;
    assign dq_oe  = r_q.oe;

    // Accepted request opens the row on the next cycle.
    assert_accept_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> (r_q.cmd == CMD_ACT));

    // Column write lands exactly RCD clocks after ACTIVE, auto-precharge off.
    assert_write_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_WR) |-> (int'(cnt_q) == RCD_C && !addr[PRE_BIT]));

    // Masks open whenever the bus is driven.
    assert_mask_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqm == '0));

    // A drive window starts only with the WRITE command.
    assert_burst_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (r_q.cmd == CMD_WR));

    // Precharge falls at the recovery / row-active bound.
    assert_pre_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_PRE) |-> (int'(cnt_q) == PRE_T));

    // No new request is taken before the row-cycle bound.
    assert_ready_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && r_q.cmd != CMD_NOP) |-> (r_q.cmd == CMD_PRE && PRE_T + 1 >= NXT_T));
endmodule

// File: tb/sim_sdram_wr_seq.sv
module sim_sdram_wr_seq;
    localparam int TCK = 4000;
    localparam int P_RCD = 20000, P_RAS = 44000, P_WR = 15000, P_RC = 80000, P_RP = 20000;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RCD = cdiv(P_RCD, TCK);
    localparam int E_PRE = mx(E_RCD + 3 + cdiv(P_WR, TCK), cdiv(P_RAS, TCK));
    localparam int E_NXT = mx(E_PRE + cdiv(P_RP, TCK), cdiv(P_RC, TCK));

    typedef struct packed {
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic        all;
        logic [15:0] seed;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 13'h1abc, 10'h3ff, 1'b0, 16'h1234},
        '{2'd3, 13'h0001, 10'h000, 1'b1, 16'hfedc},
        '{2'd0, 13'h1fff, 10'h155, 1'b0, 16'h0f0f},
        '{2'd2, 13'h0aaa, 10'h2aa, 1'b1, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_all_banks = 1'b0;
    logic [63:0] req_data = '0;
    logic        ready, cs_n, ras_n, cas_n, we_n, dq_oe;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [1:0]  dqm;
    logic [15:0] dq_out;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sdram_wr_seq #(
        .TCK_PS(TCK), .TRCD_PS(P_RCD), .TRAS_PS(P_RAS), .TWR_PS(P_WR),
        .TRC_PS(P_RC), .TRP_PS(P_RP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_all_banks(req_all_banks),
        .req_data(req_data), .ready(ready), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [15:0] wd(input vec_t v, input int i);
        return v.seed + 16'(i) * 16'h1111;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        req_valid     = vld;
        req_bank      = v.bank;
        req_row       = v.row;
        req_col       = v.col;
        req_all_banks = v.all;
        for (int i = 0; i < 4; i++) req_data[i*16 +: 16] = wd(v, i);
    endtask

    // Expected outputs in cycle k of a sequence (cycle 0 = ACTIVE).
    task automatic check_cycle(input int k, input vec_t v);
        logic [3:0] cmd;
        cmd = {cs_n, ras_n, cas_n, we_n};
        if (k == 0) begin
            chk("R2 cmd", 32'(cmd), 32'h3);
            chk("R2 ba", 32'(ba), 32'(v.bank));
            chk("R2 row", 32'(addr), 32'(v.row));
        end else if (k == E_RCD) begin
            chk("R3 cmd", 32'(cmd), 32'h4);
            chk("R3 ba", 32'(ba), 32'(v.bank));
            chk("R3 col", 32'(addr), 32'(v.col) & 32'h3ff);
        end else if (k == E_PRE) begin
            chk("R5 cmd", 32'(cmd), 32'h2);
            chk("R6 ba", 32'(ba), 32'(v.bank));
            chk("R6 a10", 32'(addr), 32'(v.all) << 10);
        end else begin
            chk("R9 cmd", 32'(cmd), 32'h7);
            chk("R9 ba/addr", {17'(addr), 15'(ba)}, 32'h0);
        end
        if (k >= E_RCD && k < E_RCD + 4) begin
            chk("R4 oe", 32'(dq_oe), 32'h1);
            chk("R4 dqm", 32'(dqm), 32'h0);
            chk("R4 data", 32'(dq_out), 32'(wd(v, k - E_RCD)));
        end else begin
            chk("R4 oe off", 32'(dq_oe), 32'h0);
            chk("R4 dqm off", 32'(dqm), 32'h3);
        end
        chk("R7 ready", 32'(ready), 32'(k == E_NXT - 1));
    endtask

    task automatic check_idle(input string rq);
        chk(rq, {26'(ready), cs_n, ras_n, cas_n, we_n, dq_oe, 1'b0}, {26'h1, 4'h7, 2'b00});
        chk(rq, {16'(dqm), 3'(ba), 13'(addr)}, {16'h3, 16'h0});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        vec_t nv;
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after release");

        // Vector table; the next request is held valid during each sequence (R8).
        drive(VEC[0], 1'b1);
        for (int v = 0; v < NV; v++) begin
            @(posedge clk);
            @(negedge clk);
            if (v + 1 < NV) drive(VEC[v + 1], 1'b1);
            else            req_valid = 1'b0;
            for (int k = 0; k < E_NXT; k++) begin
                check_cycle(k, VEC[v]);
                if (k < E_NXT - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        check_idle("R8 idle after last");

        // Reset during the data burst (R10).
        drive(VEC[2], 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (E_RCD + 1) @(negedge clk);
        chk("R10 mid-burst oe", 32'(dq_oe), 32'h1);
        rst_n = 1'b0;
        #1;
        check_idle("R10 reset abort");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10 idle after release");
        nv = VEC[3];
        nv.row = 13'h0555;
        drive(nv, 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < E_NXT; k++) begin
            check_cycle(k, nv);
            @(negedge clk);
        end
        check_idle("R10 R7 idle after rerun");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule